// File: doc/BRIEF.md
# Receive Protection Switch Controller

This block sits on the receive side of an eight-channel link interface. The channels are fixed into four main/protect pairs: channel 2p is the main link and channel 2p+1 is its protect link. Every channel has an output slot that carries a parallel data word and a serial overhead bit. For each pair, the main channel's slot carries whichever of the two links is currently selected. The protect channel's slot always carries its own channel.

Each pair takes its select either from a dedicated interface pin or from a software select bit. A per-pair mode bit chooses the source. The two sources reach different paths. Pin control steers only the parallel word, and the main slot's overhead bit stays tied to the main channel. Register control steers both the parallel word and the overhead bit.

Software enables or powers down each channel on its own. An output slot fed from a powered-down channel drops its enables and its data goes to zero. A small synchronous register port holds the enables, the modes, the software selects and a per-channel work/protect input-select bit. That input-select bit is driven straight out to the front-end logic.

Top module: `rx_protect_switch`

## Requirements
- R1: After reset, all channel enables read 0, all mode bits read 0 (pin control), all software selects read 1 (main), and all input selects read 0 (work). Every output enable is low and every output data and overhead bit is 0.
- R2: Slot 2p+1 always carries channel 2p+1's data and overhead, with both of its enables equal to that channel's enable bit.
- R3: In pin mode (mode bit p = 0), pin_sel_i[p] = 1 puts channel 2p's data on slot 2p and 0 puts channel 2p+1's data there. Slot 2p's overhead bit and overhead enable follow channel 2p, whatever the select is. The software select bit has no effect in this mode.
- R4: In register mode (mode bit p = 1), software select bit p picks the channel in the same way (1 = main, 0 = protect) for both the data word and the overhead bit. pin_sel_i[p] has no effect in this mode.
- R5: When the channel feeding a slot's data or overhead is disabled, the matching enable output is 0 and the matching data or overhead value is 0.
- R6: Outputs are registered. A change on the data, overhead or pin inputs, or a register write, shows at the outputs after exactly one rising clock edge and not before.
- R7: Register map, on a 2-bit address with a 2*NPAIR-bit data word:
  - Address 0 holds the channel enables; bit i = 1 enables channel i.
  - Address 1 holds the mode bits in bits NPAIR-1:0; 1 means register control.
  - Address 2 holds the software selects in bits NPAIR-1:0; 1 means main.
  - Address 3 holds the input selects; bit i = 1 means protect input.
  - Unused upper bits read 0.
  - Read data is combinational from reg_addr_i.
- R8: in_prot_sel_o equals the address 3 register from the clock edge that writes it.
- R9: A write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_data_i | input | 2*NPAIR*DW | Parallel word of channel i in bits i*DW +: DW |
| ch_oh_i | input | 2*NPAIR | Serial overhead bit per channel |
| pin_sel_i | input | NPAIR | Per-pair select pin, 1 = main |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 2*NPAIR | Register write data |
| reg_rdata_o | output | 2*NPAIR | Register read data |
| port_data_o | output | 2*NPAIR*DW | Parallel word per output slot |
| port_oh_o | output | 2*NPAIR | Overhead bit per output slot |
| port_data_oe_o | output | 2*NPAIR | Parallel-bus enable per slot |
| port_oh_oe_o | output | 2*NPAIR | Overhead enable per slot |
| in_prot_sel_o | output | 2*NPAIR | Work/protect input select per channel |

## Verification
A wrong mode, select or enable bit shows at the slot outputs one edge after it is stored. It appears either as the wrong channel's word or overhead bit, or as an enable that disagrees with the source channel. A stray write to a neighbouring register shows immediately on the combinational read port. Every pair is swept through both modes, both select values and all four enable combinations of its two channels. In each case the unused control source is set to the opposite select, so a leak from that source is caught on the same cycle.

// File: rtl/rx_protect_switch.sv
module rx_protect_switch #(
  parameter int DW    = 8,
  parameter int NPAIR = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*NPAIR*DW-1:0]   ch_data_i,
  input  logic [2*NPAIR-1:0]      ch_oh_i,
  input  logic [NPAIR-1:0]        pin_sel_i,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [2*NPAIR-1:0]      reg_wdata_i,
  output logic [2*NPAIR-1:0]      reg_rdata_o,
  output logic [2*NPAIR*DW-1:0]   port_data_o,
  output logic [2*NPAIR-1:0]      port_oh_o,
  output logic [2*NPAIR-1:0]      port_data_oe_o,
  output logic [2*NPAIR-1:0]      port_oh_oe_o,
  output logic [2*NPAIR-1:0]      in_prot_sel_o
);
  localparam int NCH = 2 * NPAIR;

  logic [NCH-1:0]   en_q;
  logic [NPAIR-1:0] mode_q;
  logic [NPAIR-1:0] swsel_q;
  logic [NCH-1:0]   wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mode_q  <= '0;
      swsel_q <= '1;
      wp_q    <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        2'd0:    en_q    <= reg_wdata_i;
        2'd1:    mode_q  <= reg_wdata_i[NPAIR-1:0];
        2'd2:    swsel_q <= reg_wdata_i[NPAIR-1:0];
        default: wp_q    <= reg_wdata_i;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      2'd0:    reg_rdata_o = en_q;
      2'd1:    reg_rdata_o[NPAIR-1:0] = mode_q;
      2'd2:    reg_rdata_o[NPAIR-1:0] = swsel_q;
      default: reg_rdata_o = wp_q;
    endcase
  end

  assign in_prot_sel_o = wp_q;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int M = 2 * p;
    localparam int Q = 2 * p + 1;

    logic          take_main;
    logic          oh_prot;
    logic [DW-1:0] d_src;
    logic          d_en;
    logic          o_src;
    logic          o_en;

    assign take_main = mode_q[p] ? swsel_q[p] : pin_sel_i[p];
    assign oh_prot   = mode_q[p] & ~take_main;
    assign d_src     = take_main ? ch_data_i[M*DW +: DW] : ch_data_i[Q*DW +: DW];
    assign d_en      = take_main ? en_q[M] : en_q[Q];
    assign o_src     = oh_prot ? ch_oh_i[Q] : ch_oh_i[M];
    assign o_en      = oh_prot ? en_q[Q] : en_q[M];

    logic [DW-1:0] m_data_q, q_data_q;
    logic          m_oh_q, q_oh_q, m_doe_q, q_doe_q, m_ooe_q, q_ooe_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_data_q <= '0;
        q_data_q <= '0;
        m_oh_q   <= 1'b0;
        q_oh_q   <= 1'b0;
        m_doe_q  <= 1'b0;
        q_doe_q  <= 1'b0;
        m_ooe_q  <= 1'b0;
        q_ooe_q  <= 1'b0;
      end else begin
        m_data_q <= d_en ? d_src : '0;
        m_doe_q  <= d_en;
        m_oh_q   <= o_en & o_src;
        m_ooe_q  <= o_en;
        q_data_q <= en_q[Q] ? ch_data_i[Q*DW +: DW] : '0;
        q_doe_q  <= en_q[Q];
        q_oh_q   <= en_q[Q] & ch_oh_i[Q];
        q_ooe_q  <= en_q[Q];
      end
    end

    assign port_data_o[M*DW +: DW] = m_data_q;
    assign port_data_o[Q*DW +: DW] = q_data_q;
    assign port_oh_o[M]      = m_oh_q;
    assign port_oh_o[Q]      = q_oh_q;
    assign port_data_oe_o[M] = m_doe_q;
    assign port_data_oe_o[Q] = q_doe_q;
    assign port_oh_oe_o[M]   = m_ooe_q;
    assign port_oh_oe_o[Q]   = q_ooe_q;
  end
endmodule

// File: rtl/rx_protect_switch_chk.sv
module rx_protect_switch_chk #(
  parameter int DW    = 8,
  parameter int NPAIR = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2*NPAIR*DW-1:0] ch_data_i,
  input logic [2*NPAIR-1:0]    ch_oh_i,
  input logic                  reg_we_i,
  input logic [1:0]            reg_addr_i,
  input logic [2*NPAIR-1:0]    reg_wdata_i,
  input logic [2*NPAIR*DW-1:0] port_data_o,
  input logic [2*NPAIR-1:0]    port_oh_o,
  input logic [2*NPAIR-1:0]    port_data_oe_o,
  input logic [2*NPAIR-1:0]    port_oh_oe_o,
  input logic [2*NPAIR-1:0]    in_prot_sel_o,
  input logic [2*NPAIR-1:0]    en_q,
  input logic [NPAIR-1:0]      mode_q
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && port_data_oe_o == '0 && port_oh_oe_o == '0));

  p_prot_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == 2'd3) |=> in_prot_sel_o == $past(reg_wdata_i));

  for (genvar i = 0; i < 2*NPAIR; i++) begin : g_slot
    p_data_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !port_data_oe_o[i] |-> port_data_o[i*DW +: DW] == '0);
    p_oh_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !port_oh_oe_o[i] |-> !port_oh_o[i]);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pr
    p_prot_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
      port_data_oe_o[2*p+1] == $past(en_q[2*p+1]) &&
      port_data_o[(2*p+1)*DW +: DW] ==
        ($past(en_q[2*p+1]) ? $past(ch_data_i[(2*p+1)*DW +: DW]) : '0));
    p_pin_oh_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mode_q[p]) |->
        (port_oh_oe_o[2*p] == $past(en_q[2*p]) &&
         port_oh_o[2*p] == ($past(en_q[2*p]) & $past(ch_oh_i[2*p]))));
    p_reg_both_paths_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode_q[p]) |-> port_oh_oe_o[2*p] == port_data_oe_o[2*p]);
  end
endmodule

bind rx_protect_switch rx_protect_switch_chk #(.DW(DW), .NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_data_i(ch_data_i), .ch_oh_i(ch_oh_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .port_data_o(port_data_o), .port_oh_o(port_oh_o),
  .port_data_oe_o(port_data_oe_o), .port_oh_oe_o(port_oh_oe_o),
  .in_prot_sel_o(in_prot_sel_o), .en_q(en_q), .mode_q(mode_q)
);

// File: tb/rx_protect_switch_tb.sv
module rx_protect_switch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ch_data_i = '0;
  logic [7:0]  ch_oh_i = '0;
  logic [3:0]  pin_sel_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [63:0] port_data_o;
  logic [7:0]  port_oh_o, port_data_oe_o, port_oh_oe_o, in_prot_sel_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_en, m_oh;
  logic [3:0] m_mode, m_sw, m_pin;
  logic [7:0] m_d [8];

  rx_protect_switch #(.DW(8), .NPAIR(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .ch_data_i(ch_data_i), .ch_oh_i(ch_oh_i),
    .pin_sel_i(pin_sel_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .port_data_o(port_data_o), .port_oh_o(port_oh_o),
    .port_data_oe_o(port_data_oe_o), .port_oh_oe_o(port_oh_oe_o),
    .in_prot_sel_o(in_prot_sel_o)
  );

  always #10 clk = ~clk;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  task automatic cmp(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [7:0] exp);
    reg_addr_i = a;
    #1;
    cmp(req, $sformatf("read addr %0d", a), {8'h0, reg_rdata_o}, {8'h0, exp});
  endtask

  task automatic drive();
    for (int c = 0; c < 8; c++) ch_data_i[c*8 +: 8] = m_d[c];
    ch_oh_i = m_oh;
    pin_sel_i = m_pin;
  endtask

  function automatic logic [15:0] expect_slot(int i);
    int src, ohs;
    logic eff;
    if (i % 2 == 1) begin
      src = i; ohs = i;
    end else begin
      eff = m_mode[i/2] ? m_sw[i/2] : m_pin[i/2];
      src = eff ? i : i + 1;
      ohs = m_mode[i/2] ? src : i;
    end
    return {5'b0, m_en[src], m_en[ohs], m_en[ohs] & m_oh[ohs],
            m_en[src] ? m_d[src] : 8'h00};
  endfunction

  task automatic chk_slot(string req, int i);
    cmp(req, $sformatf("slot %0d {doe,ooe,oh,data}", i),
        {5'b0, port_data_oe_o[i], port_oh_oe_o[i], port_oh_o[i], port_data_o[i*8 +: 8]},
        expect_slot(i));
  endtask

  initial begin
    int seed = 0;
    m_en = '0; m_mode = '0; m_sw = '1; m_pin = '0; m_oh = '0;
    for (int c = 0; c < 8; c++) m_d[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1", 2'd0, 8'h00);
    rd("R1", 2'd1, 8'h00);
    rd("R1", 2'd2, 8'h0F);
    rd("R1", 2'd3, 8'h00);
    cmp("R1", "data_oe", {8'h0, port_data_oe_o}, 16'h0);
    cmp("R1", "oh_oe", {8'h0, port_oh_oe_o}, 16'h0);
    cmp("R1", "data", port_data_o[15:0], 16'h0);
    cmp("R1", "in_prot_sel", {8'h0, in_prot_sel_o}, 16'h0);

    // R7 register map, upper bits of narrow registers read zero
    wr(2'd1, 8'hF5); rd("R7", 2'd1, 8'h05);
    wr(2'd2, 8'hA3); rd("R7", 2'd2, 8'h03);
    wr(2'd0, 8'h5A); rd("R7", 2'd0, 8'h5A);
    // R8 input select drives output right after the write edge
    wr(2'd3, 8'hC6); rd("R8", 2'd3, 8'hC6);
    cmp("R8", "in_prot_sel", {8'h0, in_prot_sel_o}, 16'h00C6);
    // R9 writes isolated
    rd("R9", 2'd0, 8'h5A);
    rd("R9", 2'd1, 8'h05);
    rd("R9", 2'd2, 8'h03);

    // Sweep: pair, mode, select, enable pair pattern (R2..R5)
    for (int p = 0; p < 4; p++) begin
      for (int md = 0; md < 2; md++) begin
        for (int sl = 0; sl < 2; sl++) begin
          for (int ec = 0; ec < 4; ec++) begin
            seed++;
            m_en = 8'hFF;
            m_en[2*p] = ec[0];
            m_en[2*p+1] = ec[1];
            m_mode = md[0] ? 4'b1111 : 4'b0000;
            m_sw = '0; m_pin = '0;
            if (md == 1) begin m_sw[p] = sl[0]; m_pin[p] = ~sl[0]; end
            else begin m_pin[p] = sl[0]; m_sw[p] = ~sl[0]; end
            for (int c = 0; c < 8; c++) m_d[c] = 8'(seed * 16 + c * 37 + 1);
            m_oh = (seed % 2 == 1) ? 8'h55 : 8'hAA;
            wr(2'd0, m_en);
            wr(2'd1, {4'h0, m_mode});
            wr(2'd2, {4'h0, m_sw});
            @(negedge clk);
            drive();
            @(negedge clk);
            for (int i = 0; i < 8; i++) begin
              if (i % 2 == 1) chk_slot("R2", i);
              else if (ec != 3) chk_slot("R5", i);
              else if (md == 1) chk_slot("R4", i);
              else chk_slot("R3", i);
            end
          end
        end
      end
    end

    // R6 one-edge latency on a pin change
    m_en = 8'hFF; m_mode = '0; m_pin = 4'hF;
    wr(2'd0, m_en);
    wr(2'd1, 8'h00);
    @(negedge clk); drive();
    @(negedge clk);
    chk_slot("R6", 0);
    m_pin = 4'h0; drive();
    #1;
    cmp("R6", "slot 0 before edge", {8'h0, port_data_o[7:0]}, {8'h0, m_d[0]});
    @(negedge clk);
    chk_slot("R6", 0);
    cmp("R6", "slot 0 after edge", {8'h0, port_data_o[7:0]}, {8'h0, m_d[1]});

    report();
  end
endmodule